// File: doc/BRIEF.md
# Stereo Volume Attenuator with Soft Mute

This block scales a stream of signed stereo samples by a gain chosen with a small volume code. The code picks an attenuation on a decibel curve. The upper part of the range moves in single-decibel steps. The last few codes take wider steps, and the highest codes silence the output completely. The gains are fixed-point values with one integer bit and are computed when the design is elaborated, so the ROM holds no hand-written table.

A mute input does not cut the signal at once. It drives a ramp multiplier that moves toward zero by a fixed amount on each strobed sample. When mute is released, the multiplier climbs back to unity in the same steps. The volume gain and the ramp multiplier are combined into one effective gain, which is captured together with each sample. Both channels of a frame are therefore scaled alike, and changes to the controls between strobes do nothing. The block sits between a serial audio receiver and the interpolation path. It delivers one result pair for every input pair, two clock edges later.

Top module: `vlm_volume_mute`

## Requirements
- R1: Volume codes 0 to 52 give an attenuation of that many decibels. The table gain is round(32768 * 10^(-code/20)) in unsigned Q1.15, so code 0 gives exactly 32768.
- R2: Codes 53, 54 and 55 give 54, 57 and 60 dB of attenuation, using the same rounding as R1.
- R3: Codes 56 to 63 have a table gain of zero, and both outputs are exactly 0.
- R4: Each output equals floor((sample * g + 16384) / 32768), where g is the effective gain. The result is clamped to the signed 20-bit range.
- R5: During reset, out_valid is 0 and both outputs are 0. An in_valid high at a rising edge produces exactly one out_valid pulse at the second rising edge after it. out_valid is low otherwise.
- R6: vol_code and mute_en are sampled only at edges where in_valid is high. Between strobes the outputs hold their values, and control changes have no effect on later results.
- R7: The ramp multiplier is 32768 after reset. Each strobed sample with mute_en high is scaled with the current multiplier. After that sample the multiplier drops by 1024, but never below 0.
- R8: Each strobed sample with mute_en low uses the current multiplier. After that sample the multiplier rises by 1024, but never above 32768.
- R9: The effective gain is floor((table_gain * multiplier + 16384) / 32768). The same value is applied to the left and right sample of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe marking a stereo sample pair |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| vol_code | input | 6 | Attenuation code, sampled with the strobe |
| mute_en | input | 1 | Soft mute request, sampled with the strobe |
| out_valid | output | 1 | Strobe marking a scaled pair |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |

## Verification
An output pair is due at the second rising edge after the edge that accepts a strobe. The bench drives each strobe at a falling edge. At the next falling edge it checks that out_valid is still low, and one falling edge later it compares both samples with its arithmetic model. The ramp multiplier moves only after the sample that used it, so the model computes the expected value first and only then steps its own multiplier. Idle stretches with the controls changing are checked at falling edges to confirm that the outputs hold, and the next strobe shows whether any hidden state moved.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

   // Last code that still follows the single-decibel staircase.
   localparam int LAST_LINEAR_CODE = 52;

   // Attenuation in dB for a code; -1 marks the silent codes.
   function automatic int code_to_db(input int code);
      if (code <= LAST_LINEAR_CODE) return code;
      case (code)
         53:      return 54;
         54:      return 57;
         55:      return 60;
         default: return -1;
      endcase
   endfunction

   // Unsigned fixed-point gain with 'frac' fraction bits, rounded to nearest.
   function automatic int unsigned code_gain(input int code, input int frac);
      real lin;
      int  db;
      db = code_to_db(code);
      if (db < 0) return 0;
      lin = (2.0 ** frac) * (10.0 ** (-real'(db) / 20.0));
      return int'($rtoi(lin + 0.5));
   endfunction

endpackage

// File: rtl/vlm_gain_rom.sv
module vlm_gain_rom #(
   parameter int CODE_W = 6,
   parameter int GAIN_W = 16
) (
   input  logic [CODE_W-1:0] code,
   output logic [GAIN_W-1:0] gain
);
   localparam int NUM_CODES = 2 ** CODE_W;
   localparam int FRAC      = GAIN_W - 1;

   logic [GAIN_W-1:0] tbl [NUM_CODES];

   for (genvar i = 0; i < NUM_CODES; i++) begin : g_entry
      localparam int unsigned GVAL = vlm_pkg::code_gain(i, FRAC);
      assign tbl[i] = GAIN_W'(GVAL);
   end

   assign gain = tbl[code];
endmodule

// File: rtl/vlm_mute_ramp.sv
module vlm_mute_ramp #(
   parameter int GAIN_W    = 16,
   parameter int RAMP_STEP = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              mute,
   output logic [GAIN_W-1:0] mult
);
   localparam logic [GAIN_W-1:0] ONE_V  = GAIN_W'(1) << (GAIN_W - 1);
   localparam logic [GAIN_W-1:0] STEP_V = GAIN_W'(RAMP_STEP);

   logic [GAIN_W-1:0] mult_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mult_q <= ONE_V;
      end else if (advance) begin
         if (mute) begin
            mult_q <= (mult_q > STEP_V) ? mult_q - STEP_V : '0;
         end else begin
            mult_q <= ((ONE_V - mult_q) > STEP_V) ? mult_q + STEP_V : ONE_V;
         end
      end
   end

   assign mult = mult_q;
endmodule

// File: rtl/vlm_scale_lane.sv
module vlm_scale_lane #(
   parameter int DATA_W   = 20,
   parameter int GAIN_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [DATA_W-1:0] smp,
   input  logic        [GAIN_W-1:0] gain,
   output logic signed [DATA_W-1:0] res
);
   localparam int FRAC   = GAIN_W - 1;
   localparam int PROD_W = DATA_W + GAIN_W + 1;
   localparam longint MAXL = (longint'(1) <<< (DATA_W - 1)) - 1;
   localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC - 1);
   localparam logic signed [PROD_W-1:0] MAXV = PROD_W'(MAXL);
   localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] shifted;

   assign prod    = PROD_W'(smp) * $signed({1'b0, gain});
   assign shifted = (prod + HALF) >>> FRAC;

   if (SATURATE) begin : g_sat
      always_comb begin
         if (shifted > MAXV)      res = DATA_W'(MAXV);
         else if (shifted < MINV) res = DATA_W'(MINV);
         else                     res = DATA_W'(shifted);
      end
   end else begin : g_wrap
      assign res = DATA_W'(shifted);
   end
endmodule

// File: rtl/vlm_volume_mute.sv
module vlm_volume_mute #(
   parameter int DATA_W    = 20,
   parameter int CODE_W    = 6,
   parameter int GAIN_W    = 16,
   parameter int RAMP_STEP = 1024,
   parameter bit SATURATE  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_left,
   input  logic signed [DATA_W-1:0] in_right,
   input  logic        [CODE_W-1:0] vol_code,
   input  logic                     mute_en,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_left,
   output logic signed [DATA_W-1:0] out_right
);
   localparam int NUM_CH = 2;
   localparam int FRAC   = GAIN_W - 1;
   localparam int GP_W   = 2 * GAIN_W;
   localparam logic [GP_W-1:0] GHALF = GP_W'(1) << (FRAC - 1);

   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_data
      $error("vlm_volume_mute: DATA_W out of range");
   end
   if (GAIN_W < 8 || GAIN_W > 24) begin : g_bad_gain
      $error("vlm_volume_mute: GAIN_W out of range");
   end
   if (CODE_W < 6 || CODE_W > 8) begin : g_bad_code
      $error("vlm_volume_mute: CODE_W must cover the dB curve");
   end
   if (RAMP_STEP < 1 || RAMP_STEP > (1 << (GAIN_W - 1))) begin : g_bad_step
      $error("vlm_volume_mute: RAMP_STEP out of range");
   end

   logic [GAIN_W-1:0] tbl_gain;
   logic [GAIN_W-1:0] mult;
   logic [GP_W-1:0]   gprod;
   logic [GAIN_W-1:0] eff_gain;

   vlm_gain_rom #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_rom (
      .code (vol_code),
      .gain (tbl_gain)
   );

   vlm_mute_ramp #(.GAIN_W(GAIN_W), .RAMP_STEP(RAMP_STEP)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (in_valid),
      .mute    (mute_en),
      .mult    (mult)
   );

   assign gprod    = GP_W'(tbl_gain) * GP_W'(mult);
   assign eff_gain = GAIN_W'((gprod + GHALF) >> FRAC);

   // Stage 1: sample pair and its gain, captured on the strobe
   logic                     stg_valid;
   logic [GAIN_W-1:0]        stg_gain;
   logic signed [DATA_W-1:0] in_smp  [NUM_CH];
   logic signed [DATA_W-1:0] stg_smp [NUM_CH];
   logic signed [DATA_W-1:0] lane_res[NUM_CH];
   logic signed [DATA_W-1:0] out_smp [NUM_CH];
   logic                     out_v_q;

   assign in_smp[0] = in_left;
   assign in_smp[1] = in_right;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_valid <= 1'b0;
         stg_gain  <= '0;
         out_v_q   <= 1'b0;
      end else begin
         stg_valid <= in_valid;
         out_v_q   <= stg_valid;
         if (in_valid) stg_gain <= eff_gain;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_smp[c] <= '0;
         end else if (in_valid) begin
            stg_smp[c] <= in_smp[c];
         end
      end

      vlm_scale_lane #(
         .DATA_W   (DATA_W),
         .GAIN_W   (GAIN_W),
         .SATURATE (SATURATE)
      ) u_lane (
         .smp  (stg_smp[c]),
         .gain (stg_gain),
         .res  (lane_res[c])
      );

      // Stage 2: scaled result, held between strobes
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_smp[c] <= '0;
         end else if (stg_valid) begin
            out_smp[c] <= lane_res[c];
         end
      end
   end

   assign out_valid = out_v_q;
   assign out_left  = out_smp[0];
   assign out_right = out_smp[1];
endmodule

// File: rtl/vlm_volume_mute_chk.sv
module vlm_volume_mute_chk #(
   parameter int DATA_W = 20,
   parameter int GAIN_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     mute_en,
   input logic                     stg_valid,
   input logic        [GAIN_W-1:0] stg_gain,
   input logic        [GAIN_W-1:0] mult,
   input logic signed [DATA_W-1:0] stg_left,
   input logic signed [DATA_W-1:0] stg_right,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_left,
   input logic signed [DATA_W-1:0] out_right
);
   localparam logic [GAIN_W-1:0] ONE_V = GAIN_W'(1) << (GAIN_W - 1);

   function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
      logic signed [DATA_W:0] w;
      w = (DATA_W + 1)'(v);
      return (w < 0) ? -w : w;
   endfunction

   a_r5_stage_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> stg_valid);
   a_r5_out_follows_stage: assert property (@(posedge clk) disable iff (!rst_n)
      stg_valid |=> out_valid);
   a_r5_no_spurious_out: assert property (@(posedge clk) disable iff (!rst_n)
      !stg_valid |=> !out_valid);
   a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !stg_valid |=> ($stable(out_left) && $stable(out_right)));
   a_r6_mult_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(mult));
   a_r7_mult_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      mult <= ONE_V);
   a_r7_mute_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mute_en) |=> (mult <= $past(mult)));
   a_r8_release_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mute_en) |=> (mult >= $past(mult)));
   a_r3_silent_gain: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_valid && stg_gain == '0) |=> (out_left == '0 && out_right == '0));
   a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      stg_valid |=> (mag(out_left) <= mag($past(stg_left)) &&
                     mag(out_right) <= mag($past(stg_right))));
endmodule

bind vlm_volume_mute vlm_volume_mute_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .mute_en   (mute_en),
   .stg_valid (stg_valid),
   .stg_gain  (stg_gain),
   .mult      (mult),
   .stg_left  (stg_smp[0]),
   .stg_right (stg_smp[1]),
   .out_valid (out_valid),
   .out_left  (out_left),
   .out_right (out_right)
);

// File: tb/vlm_volume_mute_tb.sv
module vlm_volume_mute_tb;
   localparam int DW = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] in_left = '0;
   logic signed [DW-1:0] in_right = '0;
   logic [5:0] vol_code = '0;
   logic mute_en = 1'b0;
   logic out_valid;
   logic signed [DW-1:0] out_left;
   logic signed [DW-1:0] out_right;

   int errors = 0;
   int checks = 0;
   longint model_mult = 32768;

   always #2 clk = ~clk;

   vlm_volume_mute u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_left(in_left), .in_right(in_right),
      .vol_code(vol_code), .mute_en(mute_en),
      .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
   );

   task automatic check(input string req, input string what, input longint got, input longint exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   function automatic longint table_gain(input int code);
      int db;
      if (code <= 52) db = code;
      else if (code == 53) db = 54;
      else if (code == 54) db = 57;
      else if (code == 55) db = 60;
      else return 0;
      return longint'($rtoi(32768.0 * (10.0 ** (-real'(db) / 20.0)) + 0.5));
   endfunction

   function automatic longint floor_div(input longint a, input longint b);
      longint q;
      q = a / b;
      if ((a % b != 0) && (a < 0)) q = q - 1;
      return q;
   endfunction

   function automatic longint scaled(input longint s, input int code, input longint m);
      longint g;
      longint y;
      g = floor_div(table_gain(code) * m + 16384, 32768);
      y = floor_div(s * g + 16384, 32768);
      if (y > 524287) y = 524287;
      if (y < -524288) y = -524288;
      return y;
   endfunction

   // One strobe, checked two rising edges later at a falling edge.
   task automatic send(input string req, input longint l, input longint r,
                       input int code, input bit mute);
      longint el;
      longint er;
      el = scaled(l, code, model_mult);
      er = scaled(r, code, model_mult);
      if (mute) model_mult = (model_mult > 1024) ? model_mult - 1024 : 0;
      else      model_mult = (32768 - model_mult > 1024) ? model_mult + 1024 : 32768;
      @(negedge clk);
      in_left  = DW'(l);
      in_right = DW'(r);
      vol_code = 6'(code);
      mute_en  = mute;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R5", "out_valid one edge after strobe", longint'(out_valid), 0);
      @(negedge clk);
      check("R5", "out_valid two edges after strobe", longint'(out_valid), 1);
      check(req, $sformatf("left code %0d", code), longint'(out_left), el);
      check(req, $sformatf("right code %0d", code), longint'(out_right), er);
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      longint samples[4] = '{524287, -524288, 77777, -3};
      repeat (4) @(negedge clk);
      check("R5", "reset out_valid", longint'(out_valid), 0);
      check("R5", "reset out_left", longint'(out_left), 0);
      check("R5", "reset out_right", longint'(out_right), 0);
      rst_n = 1'b1;

      // Sweep of every code at unity ramp multiplier (R1, R2, R3, R4)
      for (int c = 0; c < 64; c++) begin
         for (int k = 0; k < 4; k++) begin
            if (c <= 52)      send("R1", samples[k], samples[3-k], c, 1'b0);
            else if (c <= 55) send("R2", samples[k], samples[3-k], c, 1'b0);
            else              send("R3", samples[k], samples[3-k], c, 1'b0);
         end
      end

      // Rounding corners at -6 dB and 0 dB (R4)
      send("R4", 1, -1, 6, 1'b0);
      send("R4", 3, -3, 6, 1'b0);
      send("R4", 524287, -524288, 0, 1'b0);

      // Controls wiggled between strobes must change nothing (R6)
      send("R6", 100000, -200000, 3, 1'b0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         vol_code = 6'(60 - i);
         mute_en  = 1'b1;
         check("R6", "out_valid idle", longint'(out_valid), 0);
         check("R6", "out_left held", longint'(out_left), scaled(100000, 3, 32768));
         check("R6", "out_right held", longint'(out_right), scaled(-200000, 3, 32768));
      end
      send("R6", 300000, -300000, 10, 1'b0);

      // Soft mute ramp down to silence (R7, R9)
      for (int i = 0; i < 36; i++) send("R7", 400000, -250001, 0, 1'b1);
      check("R7", "silent after ramp", longint'(out_left), 0);
      // Ramp down with an attenuated code mixed in (R9)
      send("R9", 400000, -400000, 20, 1'b1);

      // Release back to unity (R8, R9)
      for (int i = 0; i < 20; i++) send("R8", 400000, -250001, 4, 1'b0);
      for (int i = 0; i < 8; i++)  send("R9", 123457, -98765, 1, 1'b1);
      for (int i = 0; i < 16; i++) send("R8", 123457, -98765, 1, 1'b0);
      send("R8", 524287, -524288, 0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule